// File: doc/BRIEF.md
# Dual-Space Random Access Port with Command Registers

This block is the random access side of a two-port buffer memory, modelled as a synchronous bus. A single set of address, data and read/write pins reaches one of two spaces, picked by two active-low selects. With the array select low, the port reads or writes the word array. With the command select low, it reads or writes a small register file instead. That file holds the start and end addresses of two buffers and a control word, all of which feed the sequential side. It also holds a read-only view of that side's two end-of-buffer flags. Each byte lane has its own active-low enable, for reads and writes alike.

Writes take effect on the rising clock edge. Reads are combinational, and read data is driven only when the output enable is low and the cycle is a read. If both selects are low, that is an illegal select: it is flagged on `sel_err` and performs no access. If both selects are high, the port is idle and all contents are kept. The block also carries a narrow port for the sequential side. When both sides write the same word on the same edge, the random side wins on the lanes it enables.

Top module: `dualspace_port`

## Requirements
- R1: With arr_sel_n=0, cmd_sel_n=1 and wr_n=0, the rising edge stores wdata at addr, only on enabled lanes (lb_n=0 enables bits 7:0, ub_n=0 enables bits 15:8).
- R2: With arr_sel_n=0, cmd_sel_n=1 and wr_n=1, the word at addr is presented on rdata in the same cycle.
- R3: lane_oe[0] (bits 7:0) and lane_oe[1] (bits 15:8) are high only when oe_n=0, wr_n=1, that lane's enable is low and exactly one select is low. Bits of an undriven lane read 0.
- R4: When both selects are low, sel_err=1, nothing is driven, and neither the array nor any register is written.
- R5: When both selects are high, nothing is written or driven, and the array keeps its contents.
- R6: With cmd_sel_n=0 and arr_sel_n=1, only addr[2:0] picks a register: 0 start1, 1 end1, 2 start2, 3 end2, 4 flags, 5 control, 6 and 7 unused. A write stores wdata[11:0], with lb_n gating bits 7:0 and ub_n gating bits 11:8. A read returns the 12-bit value zero-extended to 16 bits.
- R7: Register contents appear on the cfg_* outputs from the cycle after the write, and change at no other time.
- R8: Register 4 reads {14'b0, eob_flags} live. Writes to 4, 6 and 7 have no effect, and 6 and 7 read 0.
- R9: rst_n low clears all five registers to 0 at once, without waiting for a clock edge. The array is not cleared.
- R10: seq_we=1 writes seq_wdata at seq_addr on the rising edge, and seq_rdata shows the word at seq_addr combinationally. On the same word in the same edge, lanes enabled by a random write take the random data and the other lanes take the sequential data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_sel_n | input | 1 | Array space select, active low |
| cmd_sel_n | input | 1 | Command register space select, active low |
| wr_n | input | 1 | Low = write, high = read |
| oe_n | input | 1 | Read output enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| ub_n | input | 1 | Upper byte lane enable, active low |
| addr | input | ADDR_W | Word address; bits 2:0 select a register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, undriven lanes zero |
| lane_oe | output | 2 | Per-lane read drive enable |
| sel_err | output | 1 | Both selects low |
| eob_flags | input | 2 | Live end-of-buffer flags from the sequential side |
| seq_we | input | 1 | Sequential side write enable |
| seq_addr | input | ADDR_W | Sequential side address |
| seq_wdata | input | 16 | Sequential side write data |
| seq_rdata | output | 16 | Sequential side read data |
| cfg_ctrl | output | 12 | Control register |
| cfg_start1 | output | 12 | Buffer 1 start address |
| cfg_end1 | output | 12 | Buffer 1 end address |
| cfg_start2 | output | 12 | Buffer 2 start address |
| cfg_end2 | output | 12 | Buffer 2 end address |

## Verification
Full-word, lower-only and upper-only writes are each followed by full and single-lane reads. These patterns separate a lane that was wrongly written from a lane that was wrongly driven. Writes with an illegal select and with both selects high are each followed by a read of the same word, which shows whether any write leaked through. Register accesses cover every offset, including unused ones, high address bits set, and partial-lane writes to the control word. Because the eob_flags value is changed between reads, a flag read from a latched copy is caught. A same-edge write from both sides with mixed lanes shows which side owns each byte.

// File: rtl/dualspace_port.sv
module dualspace_port #(
  parameter int ADDR_W = 10,
  parameter int REG_W  = 12,
  parameter int FLAG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_sel_n,
  input  logic              cmd_sel_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic [1:0]        lane_oe,
  output logic              sel_err,
  input  logic [FLAG_W-1:0] eob_flags,
  input  logic              seq_we,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [15:0]       seq_wdata,
  output logic [15:0]       seq_rdata,
  output logic [REG_W-1:0]  cfg_ctrl,
  output logic [REG_W-1:0]  cfg_start1,
  output logic [REG_W-1:0]  cfg_end1,
  output logic [REG_W-1:0]  cfg_start2,
  output logic [REG_W-1:0]  cfg_end2
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0]      mem [DEPTH];
  logic [REG_W-1:0] bufr [4];
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] cmd_rd;
  logic [REG_W-1:0] wmask;
  logic [15:0]      rword;

  wire arr_go = !arr_sel_n && cmd_sel_n;
  wire cmd_go = arr_sel_n && !cmd_sel_n;
  wire [2:0] csel = addr[2:0];

  assign sel_err = !arr_sel_n && !cmd_sel_n;
  assign wmask   = {{(REG_W-8){~ub_n}}, {8{~lb_n}}};

  always_ff @(posedge clk) begin
    if (seq_we) mem[seq_addr] <= seq_wdata;
    if (arr_go && !wr_n && !lb_n) mem[addr][7:0]  <= wdata[7:0];
    if (arr_go && !wr_n && !ub_n) mem[addr][15:8] <= wdata[15:8];
  end

  assign seq_rdata = mem[seq_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) bufr[i] <= '0;
      ctrl_q <= '0;
    end else if (cmd_go && !wr_n) begin
      if (csel[2] == 1'b0)
        bufr[csel[1:0]] <= (bufr[csel[1:0]] & ~wmask) | (wdata[REG_W-1:0] & wmask);
      else if (csel == 3'd5)
        ctrl_q <= (ctrl_q & ~wmask) | (wdata[REG_W-1:0] & wmask);
    end
  end

  always_comb begin
    cmd_rd = '0;
    case (csel)
      3'd0, 3'd1, 3'd2, 3'd3: cmd_rd = bufr[csel[1:0]];
      3'd4:                   cmd_rd = {{(REG_W-FLAG_W){1'b0}}, eob_flags};
      3'd5:                   cmd_rd = ctrl_q;
      default:                cmd_rd = '0;
    endcase
  end

  assign rword   = arr_go ? mem[addr] : {{(16-REG_W){1'b0}}, cmd_rd};
  assign lane_oe = {2{!oe_n && wr_n && (arr_go || cmd_go)}} & ~{ub_n, lb_n};
  assign rdata   = rword & {{8{lane_oe[1]}}, {8{lane_oe[0]}}};

  assign cfg_ctrl   = ctrl_q;
  assign cfg_start1 = bufr[0];
  assign cfg_end1   = bufr[1];
  assign cfg_start2 = bufr[2];
  assign cfg_end2   = bufr[3];
endmodule

module dualspace_port_chk #(
  parameter int REG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arr_sel_n,
  input logic             cmd_sel_n,
  input logic             wr_n,
  input logic             lb_n,
  input logic             ub_n,
  input logic [2:0]       addr_lo,
  input logic [7:0]       wdata_lo,
  input logic [1:0]       lane_oe,
  input logic             sel_err,
  input logic [REG_W-1:0] cfg_ctrl,
  input logic [REG_W-1:0] cfg_start1,
  input logic [REG_W-1:0] cfg_end1,
  input logic [REG_W-1:0] cfg_start2,
  input logic [REG_W-1:0] cfg_end2
);
  p_illegal_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> lane_oe == 2'b00);

  p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> lane_oe == 2'b00);

  p_low_lane_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lb_n |-> !lane_oe[0]);

  p_high_lane_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ub_n |-> !lane_oe[1]);

  p_powerdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_sel_n && cmd_sel_n) |-> lane_oe == 2'b00);

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sel_n || !arr_sel_n || wr_n) |=>
      $stable({cfg_ctrl, cfg_start1, cfg_end1, cfg_start2, cfg_end2}));

  p_ctrl_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_sel_n && !cmd_sel_n && !wr_n && !lb_n && addr_lo == 3'd5) |=>
      cfg_ctrl[7:0] == $past(wdata_lo));
endmodule

bind dualspace_port dualspace_port_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arr_sel_n(arr_sel_n), .cmd_sel_n(cmd_sel_n),
  .wr_n(wr_n), .lb_n(lb_n), .ub_n(ub_n), .addr_lo(addr[2:0]),
  .wdata_lo(wdata[7:0]), .lane_oe(lane_oe), .sel_err(sel_err),
  .cfg_ctrl(cfg_ctrl), .cfg_start1(cfg_start1), .cfg_end1(cfg_end1),
  .cfg_start2(cfg_start2), .cfg_end2(cfg_end2)
);

// File: tb/dualspace_port_bench.sv
module dualspace_port_bench;
  localparam int ADDR_W = 10;
  localparam int NV = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arr_sel_n = 1'b1, cmd_sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0, seq_addr = '0;
  logic [15:0] wdata = '0, seq_wdata = '0;
  logic [1:0]  eob_flags = 2'b10;
  logic        seq_we = 1'b0;
  logic [15:0] rdata, seq_rdata;
  logic [1:0]  lane_oe;
  logic        sel_err;
  logic [11:0] cfg_ctrl, cfg_start1, cfg_end1, cfg_start2, cfg_end2;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  dualspace_port #(.ADDR_W(ADDR_W)) u_dualspace_port (
    .clk(clk), .rst_n(rst_n), .arr_sel_n(arr_sel_n), .cmd_sel_n(cmd_sel_n),
    .wr_n(wr_n), .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lane_oe(lane_oe), .sel_err(sel_err),
    .eob_flags(eob_flags), .seq_we(seq_we), .seq_addr(seq_addr),
    .seq_wdata(seq_wdata), .seq_rdata(seq_rdata), .cfg_ctrl(cfg_ctrl),
    .cfg_start1(cfg_start1), .cfg_end1(cfg_end1), .cfg_start2(cfg_start2),
    .cfg_end2(cfg_end2)
  );

  // {arr_sel_n,cmd_sel_n,wr_n,oe_n,lb_n,ub_n}, addr13, wdata, exp rdata, exp lane_oe, exp sel_err
  localparam logic [53:0] VT [NV] = '{
    {6'b010000, 13'h010, 16'hA5C3, 16'h0000, 2'b00, 1'b0}, // 0  R1 write
    {6'b011000, 13'h010, 16'h0000, 16'hA5C3, 2'b11, 1'b0}, // 1  R2 read
    {6'b010000, 13'h011, 16'h1111, 16'h0000, 2'b00, 1'b0}, // 2  R1
    {6'b010001, 13'h011, 16'hABCD, 16'h0000, 2'b00, 1'b0}, // 3  R1 low lane only
    {6'b011000, 13'h011, 16'h0000, 16'h11CD, 2'b11, 1'b0}, // 4  R1
    {6'b011001, 13'h011, 16'h0000, 16'h00CD, 2'b01, 1'b0}, // 5  R3 low read
    {6'b011010, 13'h010, 16'h0000, 16'hA500, 2'b10, 1'b0}, // 6  R3 high read
    {6'b011100, 13'h010, 16'h0000, 16'h0000, 2'b00, 1'b0}, // 7  R3 oe off
    {6'b000000, 13'h010, 16'h0000, 16'h0000, 2'b00, 1'b1}, // 8  R4 illegal write
    {6'b011000, 13'h010, 16'h0000, 16'hA5C3, 2'b11, 1'b0}, // 9  R4 kept
    {6'b110000, 13'h010, 16'h0000, 16'h0000, 2'b00, 1'b0}, // 10 R5 idle write
    {6'b011000, 13'h010, 16'h0000, 16'hA5C3, 2'b11, 1'b0}, // 11 R5 kept
    {6'b100000, 13'h005, 16'hFABC, 16'h0000, 2'b00, 1'b0}, // 12 R6 control
    {6'b101000, 13'h005, 16'h0000, 16'h0ABC, 2'b11, 1'b0}, // 13 R6
    {6'b100000, 13'h000, 16'h0123, 16'h0000, 2'b00, 1'b0}, // 14 R6 start1
    {6'b100000, 13'h001, 16'h0456, 16'h0000, 2'b00, 1'b0}, // 15 R6 end1
    {6'b100000, 13'h002, 16'h0789, 16'h0000, 2'b00, 1'b0}, // 16 R6 start2
    {6'b100000, 13'h003, 16'h0FED, 16'h0000, 2'b00, 1'b0}, // 17 R6 end2
    {6'b101000, 13'h000, 16'h0000, 16'h0123, 2'b11, 1'b0}, // 18 R6
    {6'b101000, 13'h003, 16'h0000, 16'h0FED, 2'b11, 1'b0}, // 19 R6
    {6'b101000, 13'h001, 16'h0000, 16'h0456, 2'b11, 1'b0}, // 20 R6
    {6'b101000, 13'h002, 16'h0000, 16'h0789, 2'b11, 1'b0}, // 21 R6
    {6'b100000, 13'h004, 16'h0FFF, 16'h0000, 2'b00, 1'b0}, // 22 R8 flag write
    {6'b101000, 13'h004, 16'h0000, 16'h0002, 2'b11, 1'b0}, // 23 R8 flags
    {6'b100001, 13'h005, 16'h0F11, 16'h0000, 2'b00, 1'b0}, // 24 R6 low lane
    {6'b101000, 13'h005, 16'h0000, 16'h0A11, 2'b11, 1'b0}, // 25 R6
    {6'b100010, 13'h005, 16'h0355, 16'h0000, 2'b00, 1'b0}, // 26 R6 high lane
    {6'b101000, 13'h005, 16'h0000, 16'h0311, 2'b11, 1'b0}, // 27 R6
    {6'b100000, 13'h007, 16'hFFFF, 16'h0000, 2'b00, 1'b0}, // 28 R8 unused
    {6'b101000, 13'h007, 16'h0000, 16'h0000, 2'b11, 1'b0}, // 29 R8
    {6'b101000, 13'h006, 16'h0000, 16'h0000, 2'b11, 1'b0}, // 30 R8
    {6'b101000, 13'h00D, 16'h0000, 16'h0311, 2'b11, 1'b0}, // 31 R6 high addr ignored
    {6'b000000, 13'h005, 16'h0000, 16'h0000, 2'b00, 1'b1}, // 32 R4 illegal reg write
    {6'b101000, 13'h005, 16'h0000, 16'h0311, 2'b11, 1'b0}, // 33 R4 kept
    {6'b101100, 13'h005, 16'h0000, 16'h0000, 2'b00, 1'b0}, // 34 R3 oe off
    {6'b101001, 13'h005, 16'h0000, 16'h0011, 2'b01, 1'b0}  // 35 R3 low only
  };

  function automatic string vec_req(int i);
    if (i <= 4) return "R1/R2";
    if (i <= 7) return "R3";
    if (i <= 9) return "R4";
    if (i <= 11) return "R5";
    if (i == 22 || i == 23 || (i >= 28 && i <= 30)) return "R8";
    if (i == 32 || i == 33) return "R4";
    if (i >= 34) return "R3";
    return "R6";
  endfunction

  task automatic drive(input logic [5:0] c, input logic [12:0] a, input logic [15:0] d);
    @(negedge clk);
    {arr_sel_n, cmd_sel_n, wr_n, oe_n, lb_n, ub_n} = c;
    addr  = a[ADDR_W-1:0];
    wdata = d;
    #3;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(6'b111111, 13'h0, 16'h0);
    // R9 reset state
    check("R9", "reset cfg", {8'h0, cfg_ctrl, cfg_start1}, 32'h0);
    check("R9", "reset end regs", {8'h0, cfg_end1, cfg_end2}, 32'h0);
    check("R3", "idle drive", {29'h0, sel_err, lane_oe}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i][53:48], VT[i][47:35], VT[i][34:19]);
      check(vec_req(i), $sformatf("vec %0d rdata", i), {16'h0, rdata}, {16'h0, VT[i][18:3]});
      check(vec_req(i), $sformatf("vec %0d oe/err", i), {29'h0, sel_err, lane_oe}, {29'h0, VT[i][0], VT[i][2:1]});
    end

    // R7 config outputs
    check("R7", "cfg_ctrl", {20'h0, cfg_ctrl}, 32'h311);
    check("R7", "cfg_start1", {20'h0, cfg_start1}, 32'h123);
    check("R7", "cfg_end1", {20'h0, cfg_end1}, 32'h456);
    check("R7", "cfg_start2", {20'h0, cfg_start2}, 32'h789);
    check("R7", "cfg_end2", {20'h0, cfg_end2}, 32'hFED);

    // R8 live flags
    eob_flags = 2'b01;
    drive(6'b101000, 13'h004, 16'h0);
    check("R8", "live flags", {16'h0, rdata}, 32'h0001);

    // R10 same-edge collision, random low lane wins
    @(negedge clk);
    {arr_sel_n, cmd_sel_n, wr_n, oe_n, lb_n, ub_n} = 6'b010001;
    addr = 10'h020; wdata = 16'h2222;
    seq_we = 1'b1; seq_addr = 10'h020; seq_wdata = 16'h1111;
    @(negedge clk);
    seq_we = 1'b0;
    {arr_sel_n, cmd_sel_n, wr_n, oe_n, lb_n, ub_n} = 6'b011000;
    #3;
    check("R10", "collision seq view", {16'h0, seq_rdata}, 32'h1122);
    check("R10", "collision rand view", {16'h0, rdata}, 32'h1122);

    // R10 sequential write alone
    @(negedge clk);
    {arr_sel_n, cmd_sel_n, wr_n, oe_n, lb_n, ub_n} = 6'b111111;
    seq_we = 1'b1; seq_addr = 10'h021; seq_wdata = 16'hBEEF;
    @(negedge clk);
    seq_we = 1'b0;
    {arr_sel_n, cmd_sel_n, wr_n, oe_n, lb_n, ub_n} = 6'b011000;
    addr = 10'h021;
    #3;
    check("R10", "seq write read back", {16'h0, rdata}, 32'hBEEF);

    // R9 asynchronous reset mid-run, array kept
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R9", "async clear ctrl/start1", {8'h0, cfg_ctrl, cfg_start1}, 32'h0);
    check("R9", "async clear others", {cfg_end1, cfg_start2, cfg_end2[7:0]}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(6'b011000, 13'h010, 16'h0);
    check("R9", "array kept over reset", {16'h0, rdata}, 32'hA5C3);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule